// File: doc/BRIEF.md
# Dual-clock 2:1 narrowing FIFO

This block moves a stream of 16-bit words from one clock domain into a second, unrelated clock domain, where the same data leaves as a stream of 8-bit bytes. Each stored word is split into two bytes. The low byte leaves first and the high byte follows. Storage holds 256 words, which is 512 bytes. Only pointers cross between the domains. Each pointer is Gray-coded in its home domain and then re-timed by a chain of flip-flops in the other domain.

Each side reports its own status in its own units. The writer sees a fill level counted in words, a full flag and an empty flag. The reader sees a fill level counted in bytes, a full flag and an empty flag. The reader's full flag lets a consumer wait until a complete buffer-load has arrived. Because of the synchronizer delay, a flag may be pessimistic for a few cycles. A flag never lets a write go into a full store and never lets a read come out of an empty one.

The only clear is one asynchronous, active-high input that resets both domains. Release of that clear is re-timed inside each domain.

Top module: `xclk_split_fifo`

## Requirements
- R1: While `arst` is high, and after it is released, `wr_used` and `rd_used` are 0, `wr_empty` and `rd_empty` are 1, and `wr_full` and `rd_full` are 0.
- R2: A write is taken on a rising `wr_clk` edge when `wr_en` is 1 and `wr_full` is 0. `wr_used` counts in 16-bit words and includes that write right after the same edge. After a single write into an empty FIFO, `wr_used` reads 1, and within 12 `rd_clk` cycles `rd_used` reads 2.
- R3: For each stored word, bits [7:0] are read out before bits [15:8]. `rd_data` shows the byte on the `rd_clk` edge that takes the read.
- R4: A write attempted while `wr_full` is 1 stores nothing and does not raise `wr_used`. The rejected word never appears at `rd_data`.
- R5: A read attempted while `rd_empty` is 1 leaves `rd_data` unchanged and does not advance the read position.
- R6: `wr_full` is 1 exactly when `wr_used` is 256. `wr_empty` is 1 exactly when `wr_used` is 0. Both flags are never 1 at once.
- R7: `rd_full` is 1 when 512 bytes are readable, and `rd_used` then reads 0 because it is 9 bits wide. Otherwise `rd_used` is the readable byte count. `rd_empty` is 1 when no byte is readable.
- R8: `wr_used` never grows in a cycle without `wr_en`. Once `rd_empty` is 0, it stays 0 until a read is requested.
- R9: With both clocks running freely and both ports throttled, the bytes read out equal the written words split low-byte-first, in order, with nothing lost or duplicated.
- R10: Raising `arst` at any moment clears the status of both sides at once, without waiting for a clock edge. After the clear is released, the FIFO works again from empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| arst | input | 1 | Asynchronous clear for both domains, active high |
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 16 | Word to store |
| wr_full | output | 1 | Write side: no free word slot |
| wr_empty | output | 1 | Write side: nothing stored |
| wr_used | output | 9 | Write side: stored words |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 8 | Byte taken by the most recent accepted read |
| rd_full | output | 1 | Read side: 512 bytes readable |
| rd_empty | output | 1 | Read side: no readable byte |
| rd_used | output | 9 | Read side: readable bytes, low 9 bits |

## Verification
The assertions take for granted that `wr_en` and `rd_en` settle well away from their own clock edges. They also assume that `arst` is held high from time zero until both clocks have ticked. A check that `rd_data` holds over a refused read is only meaningful once a byte has been read, since the output register is not cleared. The bench therefore changes every input on a falling edge and raises `arst` before any clock edge. It reads `rd_data` only on the falling edge that follows an accepted read. Overflow and underflow attempts are made on purpose, and the outputs are then inspected before the next legal access.

// File: rtl/xsf_pkg.sv
package xsf_pkg;

  // Status pair kept by each side of the FIFO.
  typedef struct packed {
    logic full;
    logic empty;
  } side_flags_t;

  localparam side_flags_t FLAGS_CLEAR = '{full: 1'b0, empty: 1'b1};

endpackage

// File: rtl/xsf_gray_sync.sv
// Re-times a Gray-coded pointer into another clock domain and returns it in binary.
module xsf_gray_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  // Each binary bit is the XOR of all Gray bits at and above it.
  for (genvar i = 0; i < W; i++) begin : g_bin
    assign bin_out[i] = ^(stg[STAGES-1] >> i);
  end

endmodule

// File: rtl/xsf_store.sv
// Word-wide storage written in the write domain and read one lane at a time.
module xsf_store #(
  parameter int AW    = 8,
  parameter int WW    = 16,
  parameter int RATIO = 2,
  localparam int RW   = WW / RATIO,
  localparam int SW   = $clog2(RATIO)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  input  logic [SW-1:0] rlane,
  output logic [RW-1:0] rdata
);

  logic [WW-1:0] mem [2**AW];
  logic [WW-1:0] word_q;
  logic [SW-1:0] lane_q;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) begin
      word_q <= mem[raddr];
      lane_q <= rlane;
    end
  end

  always_comb begin
    rdata = word_q[RW-1:0];
    for (int i = 1; i < RATIO; i++) begin
      if (lane_q == SW'(i)) rdata = word_q[i*RW +: RW];
    end
  end

endmodule

// File: rtl/xsf_wr_side.sv
// Write-domain pointer, word-unit fill level and flags.
module xsf_wr_side #(
  parameter int AW   = 8,
  parameter int SYNC = 2,
  localparam int PW  = AW + 1
) (
  input  logic                   clk,
  input  logic                   arst,
  input  logic                   wr_en,
  input  logic [PW-1:0]          peer_gray,
  output logic                   we,
  output logic [AW-1:0]          waddr,
  output logic [PW-1:0]          own_gray,
  output logic [PW-1:0]          used,
  output xsf_pkg::side_flags_t   flags
);

  localparam logic [PW-1:0] CAP = {1'b1, {AW{1'b0}}};

  logic [1:0]    rst_q;
  logic          rst;
  logic [PW-1:0] peer_bin, ptr_q, ptr_nxt, lvl_nxt;

  // Clear is applied at once and released on this domain's clock.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) rst_q <= 2'b11;
    else      rst_q <= {rst_q[0], 1'b0};
  end
  assign rst = rst_q[1];

  xsf_gray_sync #(.W(PW), .STAGES(SYNC)) u_rd_ptr_sync (
    .clk     (clk),
    .rst     (rst),
    .gray_in (peer_gray),
    .bin_out (peer_bin)
  );

  assign we      = wr_en & ~flags.full;
  assign waddr   = ptr_q[AW-1:0];
  assign ptr_nxt = ptr_q + {{AW{1'b0}}, we};
  assign lvl_nxt = ptr_nxt - peer_bin;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ptr_q    <= '0;
      own_gray <= '0;
      used     <= '0;
      flags    <= xsf_pkg::FLAGS_CLEAR;
    end else begin
      ptr_q       <= ptr_nxt;
      own_gray    <= ptr_nxt ^ (ptr_nxt >> 1);
      used        <= lvl_nxt;
      flags.full  <= (lvl_nxt == CAP);
      flags.empty <= (lvl_nxt == '0);
    end
  end

endmodule

// File: rtl/xsf_rd_side.sv
// Read-domain lane pointer, lane-unit fill level and flags.
module xsf_rd_side #(
  parameter int AW   = 8,
  parameter int SW   = 1,
  parameter int SYNC = 2,
  localparam int PW  = AW + 1,
  localparam int RP  = AW + SW + 1
) (
  input  logic                   clk,
  input  logic                   arst,
  input  logic                   rd_en,
  input  logic [PW-1:0]          peer_gray,
  output logic                   re,
  output logic [AW-1:0]          raddr,
  output logic [SW-1:0]          rlane,
  output logic [PW-1:0]          own_gray,
  output logic [PW-1:0]          used,
  output xsf_pkg::side_flags_t   flags
);

  localparam logic [RP-1:0] CAP = {1'b1, {(AW+SW){1'b0}}};

  logic [1:0]    rst_q;
  logic          rst;
  logic [PW-1:0] peer_bin, wptr_nxt;
  logic [RP-1:0] ptr_q, ptr_nxt, lvl_nxt, peer_lanes;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) rst_q <= 2'b11;
    else      rst_q <= {rst_q[0], 1'b0};
  end
  assign rst = rst_q[1];

  xsf_gray_sync #(.W(PW), .STAGES(SYNC)) u_wr_ptr_sync (
    .clk     (clk),
    .rst     (rst),
    .gray_in (peer_gray),
    .bin_out (peer_bin)
  );

  assign re         = rd_en & ~flags.empty;
  assign raddr      = ptr_q[AW+SW-1:SW];
  assign rlane      = ptr_q[SW-1:0];
  assign ptr_nxt    = ptr_q + {{(RP-1){1'b0}}, re};
  // A word slot is handed back only once all of its lanes are consumed.
  assign wptr_nxt   = ptr_nxt[RP-1:SW];
  assign peer_lanes = {peer_bin, {SW{1'b0}}};
  assign lvl_nxt    = peer_lanes - ptr_nxt;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ptr_q    <= '0;
      own_gray <= '0;
      used     <= '0;
      flags    <= xsf_pkg::FLAGS_CLEAR;
    end else begin
      ptr_q       <= ptr_nxt;
      own_gray    <= wptr_nxt ^ (wptr_nxt >> 1);
      used        <= lvl_nxt[PW-1:0];
      flags.full  <= (lvl_nxt == CAP);
      flags.empty <= (lvl_nxt == '0);
    end
  end

endmodule

// File: rtl/xclk_split_fifo.sv
// Dual-clock FIFO: wide words in, narrow lanes out, low lane first.
module xclk_split_fifo #(
  parameter int AW    = 8,
  parameter int WW    = 16,
  parameter int RATIO = 2,
  parameter int SYNC  = 2,
  localparam int RW   = WW / RATIO,
  localparam int SW   = $clog2(RATIO),
  localparam int CW   = AW + 1
) (
  input  logic          arst,
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [WW-1:0] wr_data,
  output logic          wr_full,
  output logic          wr_empty,
  output logic [CW-1:0] wr_used,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [RW-1:0] rd_data,
  output logic          rd_full,
  output logic          rd_empty,
  output logic [CW-1:0] rd_used
);

  xsf_pkg::side_flags_t wflags, rflags;
  logic                 we, re;
  logic [AW-1:0]        waddr, raddr;
  logic [SW-1:0]        rlane;
  logic [CW-1:0]        wgray, rgray;

  xsf_wr_side #(.AW(AW), .SYNC(SYNC)) u_wr (
    .clk       (wr_clk),
    .arst      (arst),
    .wr_en     (wr_en),
    .peer_gray (rgray),
    .we        (we),
    .waddr     (waddr),
    .own_gray  (wgray),
    .used      (wr_used),
    .flags     (wflags)
  );

  xsf_rd_side #(.AW(AW), .SW(SW), .SYNC(SYNC)) u_rd (
    .clk       (rd_clk),
    .arst      (arst),
    .rd_en     (rd_en),
    .peer_gray (wgray),
    .re        (re),
    .raddr     (raddr),
    .rlane     (rlane),
    .own_gray  (rgray),
    .used      (rd_used),
    .flags     (rflags)
  );

  xsf_store #(.AW(AW), .WW(WW), .RATIO(RATIO)) u_mem (
    .wclk  (wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .rclk  (rd_clk),
    .re    (re),
    .raddr (raddr),
    .rlane (rlane),
    .rdata (rd_data)
  );

  assign wr_full  = wflags.full;
  assign wr_empty = wflags.empty;
  assign rd_full  = rflags.full;
  assign rd_empty = rflags.empty;

endmodule

// File: rtl/xsf_sva.sv
module xsf_sva #(
  parameter int CW = 9,
  parameter int RW = 8
) (
  input logic          arst,
  input logic          wr_clk,
  input logic          wr_en,
  input logic          wr_full,
  input logic          wr_empty,
  input logic [CW-1:0] wr_used,
  input logic          rd_clk,
  input logic          rd_en,
  input logic [RW-1:0] rd_data,
  input logic          rd_full,
  input logic          rd_empty
);

  localparam logic [CW-1:0] CAP = {1'b1, {(CW-1){1'b0}}};

  // R4
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (arst)
    wr_full && wr_en |=> wr_used <= $past(wr_used));

  // R8
  wr_growth_chk: assert property (@(posedge wr_clk) disable iff (arst)
    !wr_en |=> wr_used <= $past(wr_used));

  // R6
  wr_cap_chk: assert property (@(posedge wr_clk) disable iff (arst)
    wr_used <= CAP);

  // R6
  wr_flag_pair_chk: assert property (@(posedge wr_clk) disable iff (arst)
    $onehot0({wr_full, wr_empty}));

  // R5
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (arst)
    rd_empty && rd_en |=> $stable(rd_data));

  // R8
  rd_keep_chk: assert property (@(posedge rd_clk) disable iff (arst)
    !rd_en && !rd_empty |=> !rd_empty);

  // R7
  rd_flag_pair_chk: assert property (@(posedge rd_clk) disable iff (arst)
    $onehot0({rd_full, rd_empty}));

endmodule

bind xclk_split_fifo xsf_sva #(.CW(CW), .RW(RW)) u_sva (
  .arst     (arst),
  .wr_clk   (wr_clk),
  .wr_en    (wr_en),
  .wr_full  (wr_full),
  .wr_empty (wr_empty),
  .wr_used  (wr_used),
  .rd_clk   (rd_clk),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .rd_full  (rd_full),
  .rd_empty (rd_empty)
);

// File: tb/test_xclk_split_fifo.sv
module test_xclk_split_fifo;

  localparam int CW = 9;

  logic        arst = 1'b1;
  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_full, wr_empty, rd_full, rd_empty;
  logic [CW-1:0] wr_used, rd_used;
  logic [7:0]  rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 wr_clk = ~wr_clk;   // 250 MHz write clock
  always #3 rd_clk = ~rd_clk;   // unrelated slower read clock

  xclk_split_fifo i_xclk_split_fifo (
    .arst, .wr_clk, .wr_en, .wr_data, .wr_full, .wr_empty, .wr_used,
    .rd_clk, .rd_en, .rd_data, .rd_full, .rd_empty, .rd_used
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(int k);
    logic [31:0] v;
    v = k * 32'd40503 + 32'd7;
    return v[15:0] ^ v[31:16];
  endfunction

  // Byte b of the stream: word b/2, low byte for even b.
  function automatic logic [7:0] byte_of(int b);
    logic [15:0] w;
    w = pat(b / 2);
    return (b % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  task automatic settle();
    repeat (12) @(negedge rd_clk);
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic push(int first, int n, int gap);
    int k = 0;
    int cyc = 0;
    while (k < n) begin
      @(negedge wr_clk);
      if (cyc % gap == 0) begin
        wr_en   = 1'b1;
        wr_data = pat(first + k);
        if (!wr_full) k++;
      end else begin
        wr_en = 1'b0;
      end
      cyc++;
    end
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pull(int first, int n, int gap, string req);
    int iss = 0;
    int got = 0;
    int cyc = 0;
    bit pend = 0;
    while (got < n) begin
      @(negedge rd_clk);
      if (pend) begin
        check(req, "byte", 32'(rd_data), 32'(byte_of(first + got)));
        got++;
      end
      pend = 0;
      if (iss < n && cyc % gap == 0) begin
        rd_en = 1'b1;
        if (!rd_empty) begin
          pend = 1;
          iss++;
        end
      end else begin
        rd_en = 1'b0;
      end
      cyc++;
    end
    rd_en = 1'b0;
  endtask

  task automatic check_idle(string req);
    check(req, "wr_used", 32'(wr_used), 0);
    check(req, "wr_empty", 32'(wr_empty), 1);
    check(req, "wr_full", 32'(wr_full), 0);
    check(req, "rd_used", 32'(rd_used), 0);
    check(req, "rd_empty", 32'(rd_empty), 1);
    check(req, "rd_full", 32'(rd_full), 0);
  endtask

  initial begin
    int levels [7] = '{1, 2, 3, 5, 128, 255, 256};
    logic [7:0] last;

    // R1: clear held from time zero
    repeat (3) @(negedge wr_clk);
    check_idle("R1");
    arst = 1'b0;
    settle();
    check_idle("R1");

    // R2: one word is one write slot and two read lanes
    push(0, 1, 1);
    check("R2", "wr_used", 32'(wr_used), 1);
    settle();
    check("R2", "rd_used", 32'(rd_used), 2);
    check("R2", "rd_empty", 32'(rd_empty), 0);
    check("R2", "wr_empty", 32'(wr_empty), 0);

    // R3: low byte first, then high byte
    pull(0, 2, 1, "R3");
    settle();
    check_idle("R3");

    // R5: reads from an empty FIFO change nothing
    last = byte_of(1);
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (5) @(negedge rd_clk);
    rd_en = 1'b0;
    check("R5", "rd_data", 32'(rd_data), 32'(last));
    check("R5", "rd_used", 32'(rd_used), 0);
    check("R5", "rd_empty", 32'(rd_empty), 1);
    push(10, 1, 1);
    settle();
    pull(20, 2, 1, "R5");
    settle();

    // R6 / R7 / R4: sweep of fill levels up to the full store
    foreach (levels[i]) begin
      int n = levels[i];
      push(100, n, 1);
      settle();
      check("R6", "wr_used", 32'(wr_used), 32'(n));
      check("R6", "wr_full", 32'(wr_full), 32'(n == 256));
      check("R6", "wr_empty", 32'(wr_empty), 0);
      check("R7", "rd_used", 32'(rd_used), 32'((2 * n) % 512));
      check("R7", "rd_full", 32'(rd_full), 32'(n == 256));
      check("R7", "rd_empty", 32'(rd_empty), 0);
      if (n == 256) begin
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 16'hdead;
        @(negedge wr_clk);
        wr_en = 1'b0;
        check("R4", "wr_used", 32'(wr_used), 256);
        check("R4", "wr_full", 32'(wr_full), 1);
      end
      pull(200, 2 * n, 1, "R6");
      settle();
      check_idle("R4");
    end

    // R9: free-running clocks, throttled writer then throttled reader
    fork
      push(1000, 1500, 3);
      pull(2000, 3000, 1, "R9");
    join
    settle();
    check_idle("R9");
    fork
      push(3000, 1200, 1);
      pull(6000, 2400, 4, "R9");
    join
    settle();
    check_idle("R9");

    // R10: clear in mid-operation, off any clock edge
    push(5000, 3, 1);
    settle();
    @(negedge wr_clk);
    #1 arst = 1'b1;
    #1 check_idle("R10");
    repeat (3) @(negedge rd_clk);
    arst = 1'b0;
    settle();
    check_idle("R10");
    push(6000, 1, 1);
    settle();
    check("R10", "rd_used", 32'(rd_used), 2);
    pull(12000, 2, 1, "R10");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule